// File: doc/BRIEF.md
# Seven-Slot Lane Serializer with Calibration Mode

This block is the digital core of a wide parallel-to-serial link transmitter. It runs on a fast bit clock and uses a one-cycle slot strobe. Every seventh strobe marks a word boundary. At that boundary it takes one 48-bit parallel word, plus one extra pre-formed bit per lane, and cuts them into eight 7-bit lane words. It then shifts those words out most significant slot first, one slot per strobe. A ninth lane carries a framing clock. The shape of that clock waveform tells the receiver whether the block is sending data or calibrating.

Driving the active-low training input at a boundary switches the block into calibration. The parallel input is then not taken. Every data lane sends a fixed calibration word, and the clock lane widens its high phase. A flag reports that calibration has run for the minimum number of words. An active-low power-down input clears the sequencer and turns off the lane output enable, with all serial outputs held low.

Top module: `lane_serializer7`

## Requirements
- R1: While reset is active, `ser_o`, `clk_lane_o`, `oe_o` and `train_done_o` are all 0.
- R2: Lane k's word is `{tag_i[k], data_i[6k+5:6k]}`. It is taken on the `slot_en` edge that ends slot 6, or on the first `slot_en` edge after reset or power-down. It is sent MSB first, and slot 0 is visible right after that edge.
- R3: In data mode the clock lane sends 1111000 in every word (first slot first).
- R4: In a calibration word, every data lane sends 1111000, and `data_i`/`tag_i` have no effect on it.
- R5: In a calibration word, the clock lane sends 1111100.
- R6: `train_n` is sampled only at the word boundary. A change in the middle of a word alters neither the current word nor the mode of the next word, provided `train_n` is restored before the boundary.
- R7: While `slot_en` is low, the serial outputs hold their value and no slot is consumed.
- R8: `train_done_o` rises at the boundary that ends the 4th consecutive calibration word. It stays high through later data words. It is cleared when a calibration word follows a data word, and by reset or power-down.
- R9: One edge after `pd_n` is sampled low, `oe_o` is 0 and every serial output is 0. The first `slot_en` edge with `pd_n` high starts a fresh word.
- R10: Consecutive words stream back to back with no idle slot between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_en | input | 1 | Slot strobe, one slot per high cycle |
| train_n | input | 1 | Active-low calibration request, sampled at word boundary |
| pd_n | input | 1 | Active-low power-down |
| data_i | input | 48 | Parallel data, 6 bits per lane |
| tag_i | input | 8 | Pre-formed leading slot bit per lane |
| ser_o | output | 8 | Serial data lanes |
| clk_lane_o | output | 1 | Serial framing clock lane |
| oe_o | output | 1 | Lane output enable |
| train_done_o | output | 1 | Calibration held for the minimum word count |

## Verification
Data words are driven as all zeros and all ones, which expose stuck slots and a lost tag bit. A walking pattern with distinct values per lane shows lane swaps and reversed slot order. An alternating pattern shows shifts off by one slot. Calibration words are sent with deliberately noisy parallel input, so any leak of data into a calibration word shows on the lanes. A word with idle strobe gaps and a word during which training is toggled mid-word separate boundary-only sampling and strobe gating from free-running behaviour.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
   typedef enum logic {
      MODE_DATA  = 1'b0,
      MODE_TRAIN = 1'b1
   } lsr_mode_e;
endpackage

// File: rtl/lsr_slot_seq.sv
module lsr_slot_seq #(
   parameter int SLOTS = 7,
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pd_n,
   input  logic              slot_en,
   output logic [SLOT_W-1:0] slot_o,
   output logic              load_o,
   output logic              shift_o
);
   localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

   logic [SLOT_W-1:0] slot_q;
   logic              at_end;

   assign at_end  = (slot_q == LAST);
   assign load_o  = pd_n & slot_en & at_end;
   assign shift_o = pd_n & slot_en & ~at_end;
   assign slot_o  = slot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= LAST;
      else if (!pd_n)   slot_q <= LAST;
      else if (slot_en) slot_q <= at_end ? '0 : slot_q + 1'b1;
   end
endmodule

// File: rtl/lsr_lane.sv
module lsr_lane #(
   parameter int SLOTS = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pd_n,
   input  logic             load,
   input  logic             shift,
   input  logic [SLOTS-1:0] word_i,
   output logic             bit_o
);
   logic [SLOTS-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh_q <= '0;
      else if (!pd_n) sh_q <= '0;
      else if (load)  sh_q <= word_i;
      else if (shift) sh_q <= {sh_q[SLOTS-2:0], 1'b0};
   end

   assign bit_o = sh_q[SLOTS-1];
endmodule

// File: rtl/lsr_mode_ctl.sv
module lsr_mode_ctl #(
   parameter int MIN_TRAIN = 4,
   localparam int TC_W = $clog2(MIN_TRAIN + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pd_n,
   input  logic load,
   input  logic train_n,
   output logic done_o
);
   import lsr_pkg::*;

   lsr_mode_e         mode_q;
   logic [TC_W-1:0]   tcnt_q;
   logic              done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_DATA;
         tcnt_q <= '0;
         done_q <= 1'b0;
      end else if (!pd_n) begin
         mode_q <= MODE_DATA;
         tcnt_q <= '0;
         done_q <= 1'b0;
      end else if (load) begin
         mode_q <= train_n ? MODE_DATA : MODE_TRAIN;
         if (mode_q == MODE_TRAIN) begin
            if (tcnt_q != TC_W'(MIN_TRAIN)) tcnt_q <= tcnt_q + 1'b1;
            if (tcnt_q >= TC_W'(MIN_TRAIN - 1)) done_q <= 1'b1;
         end else begin
            tcnt_q <= '0;
            if (!train_n) done_q <= 1'b0;
         end
      end
   end

   assign done_o = done_q;
endmodule

// File: rtl/lane_serializer7.sv
module lane_serializer7 #(
   parameter int LANES     = 8,
   parameter int SLOTS     = 7,
   parameter int CLK_HI    = 4,
   parameter int MIN_TRAIN = 4,
   localparam int DPL  = SLOTS - 1,
   localparam int IN_W = LANES * DPL
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slot_en,
   input  logic             train_n,
   input  logic             pd_n,
   input  logic [IN_W-1:0]  data_i,
   input  logic [LANES-1:0] tag_i,
   output logic [LANES-1:0] ser_o,
   output logic             clk_lane_o,
   output logic             oe_o,
   output logic             train_done_o
);
   localparam int SLOT_W = $clog2(SLOTS);
   localparam logic [SLOTS-1:0] ALL1     = '1;
   localparam logic [SLOTS-1:0] NORM_PAT = ~(ALL1 >> CLK_HI);

   if (SLOTS < 3 || SLOTS > 32) begin : g_bad_slots
      $error("SLOTS out of range");
   end
   if (CLK_HI < 2 || CLK_HI > SLOTS - 2) begin : g_bad_clk_hi
      $error("CLK_HI must leave room to widen or narrow the clock");
   end
   if (LANES < 1 || MIN_TRAIN < 1) begin : g_bad_count
      $error("LANES and MIN_TRAIN must be positive");
   end

   logic [SLOTS-1:0]  train_clk_pat;
   logic [SLOT_W-1:0] slot_w;
   logic              load_w;
   logic              shift_w;
   logic [LANES:0]    lane_bit;
   logic [SLOTS-1:0]  clk_word;
   logic              oe_q;

   // A clock already high for most of the word widens by one slot in
   // calibration; a narrow one shrinks by one slot.
   if (2 * CLK_HI > SLOTS) begin : g_widen
      assign train_clk_pat = ~(ALL1 >> (CLK_HI + 1));
   end else begin : g_narrow
      assign train_clk_pat = ~(ALL1 >> (CLK_HI - 1));
   end

   lsr_slot_seq #(.SLOTS(SLOTS)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .pd_n    (pd_n),
      .slot_en (slot_en),
      .slot_o  (slot_w),
      .load_o  (load_w),
      .shift_o (shift_w)
   );

   lsr_mode_ctl #(.MIN_TRAIN(MIN_TRAIN)) u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .pd_n    (pd_n),
      .load    (load_w),
      .train_n (train_n),
      .done_o  (train_done_o)
   );

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [SLOTS-1:0] word;
      assign word = train_n ? {tag_i[k], data_i[k*DPL +: DPL]} : NORM_PAT;

      lsr_lane #(.SLOTS(SLOTS)) u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .pd_n   (pd_n),
         .load   (load_w),
         .shift  (shift_w),
         .word_i (word),
         .bit_o  (lane_bit[k])
      );
   end

   assign clk_word = train_n ? NORM_PAT : train_clk_pat;

   lsr_lane #(.SLOTS(SLOTS)) u_clk_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .pd_n   (pd_n),
      .load   (load_w),
      .shift  (shift_w),
      .word_i (clk_word),
      .bit_o  (lane_bit[LANES])
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe_q <= 1'b0;
      else        oe_q <= pd_n;
   end

   assign oe_o       = oe_q;
   assign ser_o      = lane_bit[LANES-1:0] & {LANES{oe_q}};
   assign clk_lane_o = lane_bit[LANES] & oe_q;
endmodule

// File: rtl/lsr_chk.sv
module lsr_chk #(
   parameter int LANES  = 8,
   parameter int SLOTS  = 7,
   parameter int SLOT_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pd_n,
   input logic              slot_en,
   input logic              train_n,
   input logic [LANES-1:0]  tag_i,
   input logic              load,
   input logic [SLOT_W-1:0] slot,
   input logic [LANES-1:0]  ser_o,
   input logic              clk_lane_o,
   input logic              oe_o,
   input logic              train_done_o
);
   p_pd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !pd_n |=> (!oe_o && ser_o == '0 && !clk_lane_o && !train_done_o));

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_n && !slot_en) |=> ($stable(ser_o) && $stable(clk_lane_o)));

   p_tag_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (load && train_n) |=> (ser_o == $past(tag_i)));

   p_cal_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !train_n) |=> (ser_o == '1));

   p_clk_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_o && slot == '0) |-> clk_lane_o);

   p_done_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(train_done_o) |-> $past(load));

   p_slot_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      slot <= SLOT_W'(SLOTS - 1));
endmodule

bind lane_serializer7 lsr_chk #(.LANES(LANES), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pd_n         (pd_n),
   .slot_en      (slot_en),
   .train_n      (train_n),
   .tag_i        (tag_i),
   .load         (load_w),
   .slot         (slot_w),
   .ser_o        (ser_o),
   .clk_lane_o   (clk_lane_o),
   .oe_o         (oe_o),
   .train_done_o (train_done_o)
);

// File: tb/sim_lane_serializer7.sv
`timescale 1ns/1ps
module sim_lane_serializer7;
   localparam int LANES = 8;
   localparam int SLOTS = 7;
   localparam int IN_W  = 48;
   localparam logic [6:0] NORM_CLK  = 7'b1111000;
   localparam logic [6:0] TRAIN_CLK = 7'b1111100;
   localparam logic [6:0] CAL_WORD  = 7'b1111000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             slot_en = 1'b0;
   logic             train_n = 1'b1;
   logic             pd_n = 1'b1;
   logic [IN_W-1:0]  data_i = '0;
   logic [LANES-1:0] tag_i = '0;
   logic [LANES-1:0] ser_o;
   logic             clk_lane_o;
   logic             oe_o;
   logic             train_done_o;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   lane_serializer7 u0 (
      .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .train_n(train_n),
      .pd_n(pd_n), .data_i(data_i), .tag_i(tag_i), .ser_o(ser_o),
      .clk_lane_o(clk_lane_o), .oe_o(oe_o), .train_done_o(train_done_o)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [LANES*7-1:0] pack_data(input logic [IN_W-1:0] d,
                                                    input logic [LANES-1:0] t);
      logic [LANES*7-1:0] r;
      for (int k = 0; k < LANES; k++) r[k*7 +: 7] = {t[k], d[k*6 +: 6]};
      return r;
   endfunction

   function automatic logic [LANES*7-1:0] pack_cal();
      logic [LANES*7-1:0] r;
      for (int k = 0; k < LANES; k++) r[k*7 +: 7] = CAL_WORD;
      return r;
   endfunction

   // Runs one word: the next posedge must be a boundary. Inputs are already set.
   task automatic run_word(input string req, input logic [LANES*7-1:0] exp_lanes,
                           input logic [6:0] exp_clk, input int exp_done,
                           input int gap, input int flip_at);
      logic [LANES*7-1:0] got;
      logic [6:0]         gclk;
      logic [LANES-1:0]   prev;
      logic               prevc;
      got = '0;
      gclk = '0;
      slot_en = 1'b1;
      for (int s = 0; s < SLOTS; s++) begin
         @(posedge clk);
         @(negedge clk);
         for (int k = 0; k < LANES; k++) got[k*7 + 6 - s] = ser_o[k];
         gclk[6 - s] = clk_lane_o;
         if (s == 0 && exp_done >= 0)
            check(req, "train_done at boundary", 64'(train_done_o), 64'(exp_done));
         if (s == flip_at) train_n = 1'b0;
         if (s == SLOTS - 1 && flip_at >= 0) train_n = 1'b1;
         if (gap > 0 && s < SLOTS - 1) begin
            prev = ser_o;
            prevc = clk_lane_o;
            slot_en = 1'b0;
            for (int g = 0; g < gap; g++) begin
               @(posedge clk);
               @(negedge clk);
               check("R7", "hold while strobe low", 64'({ser_o, clk_lane_o}),
                     64'({prev, prevc}));
            end
            slot_en = 1'b1;
         end
      end
      check(req, "data lanes", 64'(got), 64'(exp_lanes));
      check(req, "clock lane", 64'(gclk), 64'(exp_clk));
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      slot_en = 1'b1;
      repeat (3) @(negedge clk);
      check("R1", "outputs in reset", 64'({ser_o, clk_lane_o, oe_o, train_done_o}), 64'(0));
      rst_n = 1'b1;
   endtask

   task automatic t_data_patterns();
      logic [IN_W-1:0] d;
      data_i = '0; tag_i = '0;
      run_word("R2", pack_data(data_i, tag_i), NORM_CLK, 0, 0, -1);
      check("R1", "oe after reset release", 64'(oe_o), 64'(1));
      data_i = '1; tag_i = '1;
      run_word("R10", pack_data(data_i, tag_i), NORM_CLK, 0, 0, -1);
      for (int k = 0; k < LANES; k++) d[k*6 +: 6] = 6'(1 << (k % 6)) ^ 6'(k);
      data_i = d; tag_i = 8'b1010_0101;
      run_word("R2", pack_data(data_i, tag_i), NORM_CLK, 0, 0, -1);
      data_i = {IN_W/2{2'b10}}; tag_i = 8'h0F;
      run_word("R3", pack_data(data_i, tag_i), NORM_CLK, 0, 0, -1);
   endtask

   task automatic t_gaps();
      data_i = 48'h9A3C_5E71_0FD2; tag_i = 8'h69;
      run_word("R7", pack_data(data_i, tag_i), NORM_CLK, 0, 2, -1);
   endtask

   task automatic t_training();
      train_n = 1'b0;
      for (int w = 0; w < 5; w++) begin
         data_i = 48'hDEAD_BEEF_0000 ^ 48'(w * 48'h1111_1111_1111);
         tag_i = 8'(w * 37);
         if (w == 4) train_n = 1'b1;
         if (w < 4)
            run_word("R4", pack_cal(), TRAIN_CLK, 0, 0, -1);
         else
            run_word("R8", pack_data(data_i, tag_i), NORM_CLK, 1, 0, -1);
      end
      data_i = 48'h0123_4567_89AB; tag_i = 8'h3C;
      run_word("R8", pack_data(data_i, tag_i), NORM_CLK, 1, 0, -1);
   endtask

   task automatic t_midword();
      data_i = 48'h5555_AAAA_3333; tag_i = 8'hC3;
      run_word("R6", pack_data(data_i, tag_i), NORM_CLK, 1, 0, 3);
      data_i = 48'hFEDC_BA98_7654; tag_i = 8'h81;
      run_word("R6", pack_data(data_i, tag_i), NORM_CLK, 1, 0, -1);
   endtask

   task automatic t_reentry();
      train_n = 1'b0;
      run_word("R5", pack_cal(), TRAIN_CLK, 0, 0, -1);
      train_n = 1'b1;
      data_i = 48'h1; tag_i = 8'h0;
      run_word("R3", pack_data(data_i, tag_i), NORM_CLK, 0, 0, -1);
   endtask

   task automatic t_power_down();
      train_n = 1'b0;
      for (int w = 0; w < 4; w++) run_word("R5", pack_cal(), TRAIN_CLK, -1, 0, -1);
      train_n = 1'b1;
      data_i = 48'hABCD_EF01_2345; tag_i = 8'hFF;
      slot_en = 1'b1;
      for (int s = 0; s < 3; s++) begin @(posedge clk); @(negedge clk); end
      check("R8", "done set before power-down", 64'(train_done_o), 64'(1));
      pd_n = 1'b0;
      @(posedge clk); @(negedge clk);
      check("R9", "disabled outputs", 64'({ser_o, clk_lane_o, oe_o, train_done_o}), 64'(0));
      repeat (4) @(negedge clk);
      check("R9", "stay disabled", 64'({ser_o, clk_lane_o, oe_o}), 64'(0));
      pd_n = 1'b1;
      data_i = 48'h7E7E_0101_C3C3; tag_i = 8'h5A;
      run_word("R9", pack_data(data_i, tag_i), NORM_CLK, 0, 0, -1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_data_patterns();
      t_gaps();
      t_training();
      t_midword();
      t_reentry();
      t_power_down();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule